// File: doc/BRIEF.md
# Packed SIMD Integer Multiplier Pipeline

This block multiplies three 64-bit packed operand words lane by lane. An element-width selector splits each word into eight 8-bit, four 16-bit, two 32-bit or one 64-bit lane, and every lane is computed on its own. An opcode chooses what each lane returns. It can return the low half of the product, or the high half with signed, unsigned or mixed operand signedness. It can return a signed fractional product with selectable rounding and optional saturation. It can also return one of four multiply-add or multiply-subtract forms that bring in the third operand.

Operations enter through a valid/ready handshake and leave through a second one after a parameterised number of register stages. One operation can be accepted and one retired per cycle. A per-element mask travels with each operation and comes out unchanged. A per-element flag reports lanes that saturated.

Top module: `pmul_pipe`

## Requirements
- R1: With opcode 0, each lane returns the low SEW bits of A·B. The element-width code is 0 for 8-bit, 1 for 16-bit, 2 for 32-bit and 3 for 64-bit lanes, and lane k occupies bits [k·SEW +: SEW] of every word.
- R2: Opcodes 1, 2 and 3 return bits [2·SEW-1:SEW] of the full product. Opcode 1 treats A and B as signed, opcode 2 treats both as unsigned, and opcode 3 treats A as signed and B as unsigned.
- R3: Opcodes 5 to 8 return, modulo 2^SEW: A·B+C (5), A·C+B (6), C−A·B (7) and B−A·C (8).
- R4: Opcode 4 returns the signed product A·B shifted right by SEW−1. The dropped bits are rounded by the 2-bit rounding input: 0 rounds half up, 1 rounds half to even, 2 truncates, and 3 rounds to odd by setting the LSB when any dropped bit is nonzero.
- R5: When fixed-point support is enabled and both elements of an opcode-4 lane equal the most negative value, the lane returns the largest positive value and its flag bit (bit k for lane k) is set. Every other flag bit of every operation is 0.
- R6: The 8-bit element mask leaves with its operation unchanged.
- R7: An accepted operation appears at the output exactly NUM_STAGES cycles later. With the output always ready, the input is always ready.
- R8: While the output is valid and not ready, the output data stays unchanged and valid, and no accepted operation is lost or reordered.
- R9: Reset empties every stage, so the output is not valid during and right after reset, and the input is ready once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Operation can be taken this cycle |
| opnd_a_i | input | 64 | Packed operand A |
| opnd_b_i | input | 64 | Packed operand B |
| opnd_c_i | input | 64 | Packed operand C (multiply-add forms) |
| elem_w_i | input | 2 | Element-width code |
| op_i | input | 4 | Operation code |
| rmode_i | input | 2 | Rounding mode for the fractional multiply |
| mask_i | input | 8 | Per-element mask carried along |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | 64 | Packed result |
| mask_o | output | 8 | Forwarded element mask |
| sat_o | output | 8 | Per-element saturation flags |

## Verification
The bench builds the block with its default depth of two stages and with fixed-point support enabled. At 8-bit width the lanes are small enough for every pairing of A and B values to be covered under every opcode and every rounding mode, packed eight pairs per operation. That covers every rounding tie, the single saturating pair and every sign combination. The 16-, 32- and 64-bit widths get random operands mixed with extreme values under random output stalls, which exercises holding and ordering. A final pass fills the pipe against a stalled output and then resets it.

// File: rtl/pmul_pkg.sv
`timescale 1ns/1ps
package pmul_pkg;

    localparam int unsigned WORD_W    = 64;
    localparam int unsigned MAX_LANES = 8;
    localparam int unsigned NUM_EW    = 4;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } ew_e;

    typedef enum logic [3:0] {
        OP_MUL_LO  = 4'd0,
        OP_MULH_SS = 4'd1,
        OP_MULH_UU = 4'd2,
        OP_MULH_SU = 4'd3,
        OP_FRAC    = 4'd4,
        OP_ACC_ADD = 4'd5,
        OP_DST_ADD = 4'd6,
        OP_ACC_SUB = 4'd7,
        OP_DST_SUB = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        RM_HALF_UP   = 2'd0,
        RM_HALF_EVEN = 2'd1,
        RM_CHOP      = 2'd2,
        RM_JAM_ODD   = 2'd3
    } rmode_e;

    typedef struct packed {
        logic [WORD_W-1:0]    res;
        logic [MAX_LANES-1:0] mask;
        logic [MAX_LANES-1:0] sat;
    } pkt_t;

endpackage

// File: rtl/pmul_lane.sv
`timescale 1ns/1ps
module pmul_lane
    import pmul_pkg::*;
#(
    parameter int unsigned W        = 8,
    parameter bit          FIXPT_EN = 1'b1
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    input  op_e          op_i,
    input  rmode_e       rmode_i,
    output logic [W-1:0] res_o,
    output logic         sat_o
);

    localparam int unsigned PW = 2 * W;

    logic            sgn_a, sgn_b;
    logic [PW-1:0]   ext_a, ext_b, prod;
    logic [W-1:0]    mul_rhs, addend, lo_prod;
    logic [W-1:0]    frac_q, min_v, max_v;
    logic            lsb_bit, rnd_bit, sticky, inc, both_min;

    // Sign-extend to 2W bits; the modular 2W-bit product then equals
    // the low 2W bits of the true signed or unsigned product.
    always_comb begin
        sgn_a = (op_i == OP_MULH_SS) || (op_i == OP_MULH_SU) || (op_i == OP_FRAC);
        sgn_b = (op_i == OP_MULH_SS) || (op_i == OP_FRAC);
        ext_a = {{W{sgn_a & a_i[W-1]}}, a_i};
        ext_b = {{W{sgn_b & b_i[W-1]}}, b_i};
        prod  = ext_a * ext_b;
    end

    always_comb begin
        if ((op_i == OP_DST_ADD) || (op_i == OP_DST_SUB)) begin
            mul_rhs = c_i;
            addend  = b_i;
        end else begin
            mul_rhs = b_i;
            addend  = c_i;
        end
        lo_prod = a_i * mul_rhs;
    end

    // Fractional path: keep prod[2W-2:W-1], round on the dropped bits
    always_comb begin
        min_v    = {1'b1, {(W-1){1'b0}}};
        max_v    = ~min_v;
        frac_q   = prod[PW-2:W-1];
        lsb_bit  = prod[W-1];
        rnd_bit  = prod[W-2];
        sticky   = |prod[W-3:0];
        both_min = (a_i == min_v) && (b_i == min_v);
        unique case (rmode_i)
            RM_HALF_UP:   inc = rnd_bit;
            RM_HALF_EVEN: inc = rnd_bit & (sticky | lsb_bit);
            RM_CHOP:      inc = 1'b0;
            default:      inc = ~lsb_bit & (rnd_bit | sticky);
        endcase
    end

    always_comb begin
        sat_o = 1'b0;
        unique case (op_i)
            OP_MULH_SS, OP_MULH_UU, OP_MULH_SU: res_o = prod[PW-1:W];
            OP_FRAC: begin
                if (FIXPT_EN && both_min) begin
                    res_o = max_v;
                    sat_o = 1'b1;
                end else begin
                    res_o = frac_q + {{(W-1){1'b0}}, inc};
                end
            end
            OP_ACC_ADD, OP_DST_ADD: res_o = lo_prod + addend;
            OP_ACC_SUB, OP_DST_SUB: res_o = addend - lo_prod;
            default:                res_o = lo_prod;
        endcase
    end

endmodule

// File: rtl/pmul_lanes.sv
`timescale 1ns/1ps
module pmul_lanes
    import pmul_pkg::*;
#(
    parameter bit FIXPT_EN = 1'b1
) (
    input  logic [WORD_W-1:0]    a_i,
    input  logic [WORD_W-1:0]    b_i,
    input  logic [WORD_W-1:0]    c_i,
    input  ew_e                  ew_i,
    input  op_e                  op_i,
    input  rmode_e               rmode_i,
    output logic [WORD_W-1:0]    res_o,
    output logic [MAX_LANES-1:0] sat_o
);

    logic [NUM_EW-1:0][WORD_W-1:0]    res_w;
    logic [NUM_EW-1:0][MAX_LANES-1:0] sat_w;

    for (genvar g = 0; g < NUM_EW; g++) begin : g_ew
        localparam int unsigned LW = 8 << g;
        localparam int unsigned NL = WORD_W / LW;
        for (genvar k = 0; k < NL; k++) begin : g_lane
            pmul_lane #(.W(LW), .FIXPT_EN(FIXPT_EN)) u_lane (
                .a_i     (a_i[k*LW +: LW]),
                .b_i     (b_i[k*LW +: LW]),
                .c_i     (c_i[k*LW +: LW]),
                .op_i    (op_i),
                .rmode_i (rmode_i),
                .res_o   (res_w[g][k*LW +: LW]),
                .sat_o   (sat_w[g][k])
            );
        end
        if (NL < MAX_LANES) begin : g_pad
            assign sat_w[g][MAX_LANES-1:NL] = '0;
        end
    end

    always_comb begin
        res_o = res_w[ew_i];
        sat_o = sat_w[ew_i];
    end

endmodule

// File: rtl/pmul_stage.sv
`timescale 1ns/1ps
module pmul_stage
    import pmul_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic in_valid_i,
    output logic in_ready_o,
    input  pkt_t in_data_i,
    output logic out_valid_o,
    input  logic out_ready_i,
    output pkt_t out_data_o
);

    typedef struct packed {
        logic valid;
        pkt_t data;
    } slot_t;

    slot_t slot_d, slot_q;

    // Load when empty or when the held entry leaves this cycle
    assign in_ready_o = !slot_q.valid || out_ready_i;

    always_comb begin
        slot_d = slot_q;
        if (in_ready_o) begin
            slot_d.valid = in_valid_i;
            slot_d.data  = in_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) slot_q <= '0;
        else         slot_q <= slot_d;
    end

    assign out_valid_o = slot_q.valid;
    assign out_data_o  = slot_q.data;

    a_r8_hold_when_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

    a_r7_accept_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && in_ready_o |=> out_valid_o);

endmodule

// File: rtl/pmul_pipe.sv
`timescale 1ns/1ps
module pmul_pipe
    import pmul_pkg::*;
#(
    parameter int unsigned NUM_STAGES = 2,
    parameter bit          FIXPT_EN   = 1'b1
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        in_valid_i,
    output logic        in_ready_o,
    input  logic [63:0] opnd_a_i,
    input  logic [63:0] opnd_b_i,
    input  logic [63:0] opnd_c_i,
    input  logic [1:0]  elem_w_i,
    input  logic [3:0]  op_i,
    input  logic [1:0]  rmode_i,
    input  logic [7:0]  mask_i,
    output logic        out_valid_o,
    input  logic        out_ready_i,
    output logic [63:0] result_o,
    output logic [7:0]  mask_o,
    output logic [7:0]  sat_o
);

    localparam int unsigned LAST = NUM_STAGES;

    pkt_t                  comp;
    logic [WORD_W-1:0]     lane_res;
    logic [MAX_LANES-1:0]  lane_sat;

    pkt_t                  chain_data  [LAST+1];
    logic [LAST:0]         chain_valid;
    logic [LAST:0]         chain_ready;

    pmul_lanes #(.FIXPT_EN(FIXPT_EN)) u_lanes (
        .a_i     (opnd_a_i),
        .b_i     (opnd_b_i),
        .c_i     (opnd_c_i),
        .ew_i    (ew_e'(elem_w_i)),
        .op_i    (op_e'(op_i)),
        .rmode_i (rmode_e'(rmode_i)),
        .res_o   (lane_res),
        .sat_o   (lane_sat)
    );

    always_comb begin
        comp.res  = lane_res;
        comp.mask = mask_i;
        comp.sat  = lane_sat;
    end

    assign chain_data[0]     = comp;
    assign chain_valid[0]    = in_valid_i;
    assign in_ready_o        = chain_ready[0];
    assign chain_ready[LAST] = out_ready_i;

    for (genvar s = 0; s < LAST; s++) begin : g_stage
        pmul_stage u_stage (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .in_valid_i  (chain_valid[s]),
            .in_ready_o  (chain_ready[s]),
            .in_data_i   (chain_data[s]),
            .out_valid_o (chain_valid[s+1]),
            .out_ready_i (chain_ready[s+1]),
            .out_data_o  (chain_data[s+1])
        );
    end

    assign out_valid_o = chain_valid[LAST];
    assign result_o    = chain_data[LAST].res;
    assign mask_o      = chain_data[LAST].mask;
    assign sat_o       = chain_data[LAST].sat;

    a_r5_flag_only_frac: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && (|lane_sat) |-> (op_i == OP_FRAC) && FIXPT_EN);

    a_r5_sat_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && (elem_w_i == EW_8) && lane_sat[0] |-> lane_res[7:0] == 8'h7f);

    a_r9_reset_clear: assert property (@(posedge clk_i)
        !rst_ni |=> !out_valid_o);

endmodule

// File: tb/test_pmul_pipe.sv
`timescale 1ns/1ps
module test_pmul_pipe;

    localparam int STAGES = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] opa = '0, opb = '0, opc = '0;
    logic [1:0]  ew = '0;
    logic [3:0]  op = '0;
    logic [1:0]  rm = '0;
    logic [7:0]  mask = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] result;
    logic [7:0]  mask_out, sat_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int bp_mode = 0;

    logic [63:0] q_res  [$];
    logic [7:0]  q_sat  [$];
    logic [7:0]  q_mask [$];
    int          q_op   [$];
    int          q_acc  [$];
    bit          q_lat  [$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pmul_pipe #(.NUM_STAGES(STAGES), .FIXPT_EN(1'b1)) i_pmul_pipe (
        .clk_i(clk), .rst_ni(rst_n),
        .in_valid_i(in_valid), .in_ready_o(in_ready),
        .opnd_a_i(opa), .opnd_b_i(opb), .opnd_c_i(opc),
        .elem_w_i(ew), .op_i(op), .rmode_i(rm), .mask_i(mask),
        .out_valid_o(out_valid), .out_ready_i(out_ready),
        .result_o(result), .mask_o(mask_out), .sat_o(sat_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    function automatic string req_of(input int o);
        if (o == 0) return "R1";
        if (o <= 3) return "R2";
        if (o == 4) return "R4";
        return "R3";
    endfunction

    // Arithmetic reference for one element
    function automatic void ref_elem(input int w, input logic [63:0] a, b, c,
                                     input int o, input int r,
                                     output logic [63:0] res, output bit s);
        logic [63:0]         msk;
        logic signed [131:0] sa, sb, p, q, rem, half, lim, one;
        bit                  sgna, sgnb;
        one  = 132'sd1;
        msk  = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        sgna = (o == 1) || (o == 3) || (o == 4);
        sgnb = (o == 1) || (o == 4);
        sa = $signed({68'd0, a});
        if (sgna && a[w-1]) sa = sa - (one <<< w);
        sb = $signed({68'd0, b});
        if (sgnb && b[w-1]) sb = sb - (one <<< w);
        p = sa * sb;
        s = 1'b0;
        res = '0;
        case (o)
            0: res = (a * b) & msk;
            1, 2, 3: begin
                q = p >>> w;
                res = q[63:0] & msk;
            end
            4: begin
                q    = p >>> (w - 1);
                rem  = p - (q <<< (w - 1));
                half = one <<< (w - 2);
                case (r)
                    0: if (rem >= half) q = q + one;
                    1: if ((rem > half) || ((rem == half) && q[0])) q = q + one;
                    2: ;
                    default: if ((rem != 0) && !q[0]) q = q + one;
                endcase
                lim = (one <<< (w - 1)) - one;
                if (q > lim) begin
                    q = lim;
                    s = 1'b1;
                end
                res = q[63:0] & msk;
            end
            5: res = (a * b + c) & msk;
            6: res = (a * c + b) & msk;
            7: res = (c - a * b) & msk;
            default: res = (b - a * c) & msk;
        endcase
    endfunction

    function automatic void ref_word(input logic [63:0] a, b, c, input int e,
                                     input int o, input int r,
                                     output logic [63:0] res, output logic [7:0] s8);
        int          w;
        logic [63:0] msk, ea, eb, ec, er;
        bit          es;
        w   = 8 << e;
        msk = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        res = '0;
        s8  = '0;
        for (int k = 0; k < 64 / w; k++) begin
            ea = (a >> (k * w)) & msk;
            eb = (b >> (k * w)) & msk;
            ec = (c >> (k * w)) & msk;
            ref_elem(w, ea, eb, ec, o, r, er, es);
            res = res | (er << (k * w));
            s8[k] = es;
        end
    endfunction

    task automatic send(input logic [63:0] a, b, c, input int e, input int o,
                        input int r, input logic [7:0] m);
        logic [63:0] er;
        logic [7:0]  es;
        ref_word(a, b, c, e, o, r, er, es);
        @(negedge clk);
        in_valid = 1'b1;
        opa = a; opb = b; opc = c;
        ew = 2'(e); op = 4'(o); rm = 2'(r); mask = m;
        #2;
        if (bp_mode == 0) chk(in_ready, "R7", "input ready with output ready", 64'(in_ready), 64'd1);
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
        q_res.push_back(er);
        q_sat.push_back(es);
        q_mask.push_back(m);
        q_op.push_back(o);
        q_acc.push_back(cyc);
        q_lat.push_back(bp_mode == 0);
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        while (q_res.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Output monitor: sets ready, then samples away from the edge
    logic [79:0] held;
    bit          hold_armed = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (bp_mode == 0)      out_ready = 1'b1;
            else if (bp_mode == 1) out_ready = ($urandom % 3) != 0;
            else                   out_ready = 1'b0;
            #1;
            if (!rst_n) begin
                hold_armed = 1'b0;
            end else begin
                if (hold_armed) begin
                    chk(out_valid && ({result, mask_out, sat_out} == held), "R8",
                        "stalled output held", result, held[79:16]);
                end
                if (out_valid && out_ready) begin
                    if (q_res.size() == 0) begin
                        chk(1'b0, "R8", "unexpected output", result, 64'd0);
                    end else begin
                        logic [63:0] er;
                        logic [7:0]  es, em;
                        int          eo, ea;
                        bit          el;
                        er = q_res.pop_front();
                        es = q_sat.pop_front();
                        em = q_mask.pop_front();
                        eo = q_op.pop_front();
                        ea = q_acc.pop_front();
                        el = q_lat.pop_front();
                        chk(result == er, req_of(eo), "result", result, er);
                        chk(sat_out == es, "R5", "saturation flags", 64'(sat_out), 64'(es));
                        chk(mask_out == em, "R6", "mask", 64'(mask_out), 64'(em));
                        if (el) chk((cyc - ea) == STAGES, "R7", "latency",
                                    64'(cyc - ea), 64'(STAGES));
                    end
                end
                hold_armed = out_valid && !out_ready;
                held = {result, mask_out, sat_out};
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    function automatic logic [63:0] pick(input int e, input int sel);
        logic [63:0] v;
        int          w;
        w = 8 << e;
        v = {$urandom, $urandom};
        case (sel)
            0: v = 64'd1 << (w - 1);
            1: v = (64'd1 << (w - 1)) - 64'd1;
            2: v = '0;
            3: v = '1;
            default: ;
        endcase
        return v;
    endfunction

    function automatic logic [63:0] mixed(input int e);
        logic [63:0] v, msk;
        int          w;
        w   = 8 << e;
        msk = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        v   = '0;
        for (int k = 0; k < 64 / w; k++) begin
            v = v | ((pick(e, int'($urandom % 8)) & msk) << (k * w));
        end
        return v;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid, "R9", "output valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!out_valid, "R9", "output valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready, "R9", "input ready after reset", 64'(in_ready), 64'd1);

        // Exhaustive 8-bit sweep: all (a,b) pairs, eight per operation
        bp_mode = 0;
        for (int cmb = 0; cmb < 12; cmb++) begin
            int o, r;
            o = (cmb < 4) ? cmb : ((cmb < 8) ? 4 : cmb - 3);
            r = (cmb >= 4 && cmb < 8) ? cmb - 4 : 0;
            for (int a = 0; a < 256; a++) begin
                for (int j = 0; j < 32; j++) begin
                    logic [63:0] va, vb, vc;
                    for (int k = 0; k < 8; k++) begin
                        va[k*8 +: 8] = 8'(a);
                        vb[k*8 +: 8] = 8'(j * 8 + k);
                        vc[k*8 +: 8] = 8'(a * 7 + j * 13 + k * 29);
                    end
                    send(va, vb, vc, 0, o, r, 8'(a ^ (j << 3)));
                end
            end
        end
        drain();

        // Wider lanes: random and extreme values under random stalls
        bp_mode = 1;
        for (int e = 0; e < 4; e++) begin
            for (int cmb = 0; cmb < 12; cmb++) begin
                int o, r;
                o = (cmb < 4) ? cmb : ((cmb < 8) ? 4 : cmb - 3);
                r = (cmb >= 4 && cmb < 8) ? cmb - 4 : 0;
                for (int n = 0; n < 60; n++) begin
                    send(mixed(e), mixed(e), mixed(e), e, o, r, 8'($urandom));
                end
            end
        end
        drain();

        // R9: reset with an entry stuck behind a stalled output
        bp_mode = 2;
        send(64'h0123_4567_89ab_cdef, 64'h1111_2222_3333_4444, 64'h5, 3, 0, 0, 8'h5a);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        #2;
        chk(out_valid, "R8", "entry kept under stall", 64'(out_valid), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        #2;
        chk(!out_valid, "R9", "output cleared by reset", 64'(out_valid), 64'd0);
        q_res.delete(); q_sat.delete(); q_mask.delete();
        q_op.delete(); q_acc.delete(); q_lat.delete();
        rst_n = 1'b1;
        bp_mode = 0;
        repeat (3) @(negedge clk);
        #2;
        chk(!out_valid, "R9", "no output after reset release", 64'(out_valid), 64'd0);
        chk(in_ready, "R9", "input ready after reset release", 64'(in_ready), 64'd1);
        finish_run();
    end

endmodule